// File: doc/BRIEF.md
# NAND Command Cycle Sequencer

This block turns one three-word command descriptor into the pin activity a raw NAND flash device expects: command latch, address latch, write and read strobes, chip enable and an 8-bit data bus, plus a wait on the device's ready/busy line. Control logic raises a run level. The block then asks for a descriptor and takes three 32-bit words, all written through the same write port in a fixed order. Word 0 holds the opcodes, the address-cycle count, the double-command flag and the command type. Word 1 and word 2 hold the address bytes.

The sequencer then lowers chip enable and issues the first command byte, then the address bytes and, if asked, the second command byte. Depending on the type, it either waits for the device to finish a program or erase, or reads back a burst of status or ID bytes. Every strobe phase length comes from two timing words. A phase programmed with count N lasts N+1 clocks. At the end the block gives a one-clock completion pulse and asks for the next descriptor. Dropping the run level abandons the sequence at any point.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, and whenever `run` is low, chip enable, write strobe and read strobe are all high, CLE, ALE, `io_oe` and `cmd_req` are low, and `done` is low.
- R2: One clock after `run` rises, `cmd_req` goes high and stays high until three descriptor words have been written. A `desc_wr` pulse while `cmd_req` is low is ignored and starts nothing.
- R3: In descriptor word 0, bits 7:0 are the first opcode, bits 15:8 the second opcode, bits 18:16 the address-cycle count, bit 19 the double-command flag and bits 23:21 the type (1 program, 2 erase, 3 read ID, 4 read status, 5 reset/lock).
- R4: Each command byte is driven on `io_out` with CLE high and ALE low. The write strobe is low for tWP+1 clocks (timing word 0 bits 10:8) and then high for tWH+1 clocks (bits 13:11). The byte is latched on the strobe's rising edge.
- R5: The address cycles are driven with ALE high and CLE low, in the number given by the count field. Their bytes are taken least-significant first from word 1 and then from word 2.
- R6: The second opcode is issued after the last address byte only when the double-command flag is set. Otherwise no second command cycle occurs.
- R7: For program or erase with the double-command flag set, the block waits tR+1 clocks (timing word 1 bits 31:16) and then until `rb` is high before finishing. Without the flag, it does not wait on `rb`.
- R8: For read ID and read status, the block waits tAR+1 clocks (timing word 1 bits 3:0) after the last write cycle if that cycle was an address, and tWHR+1 clocks (bits 7:4) otherwise. It then gives 8 read-strobe pulses, each low for tRP+1 clocks (timing word 0 bits 2:0) and high for tRH+1 clocks (bits 5:3). The bus value at the end of each low phase appears on `rd_data` with a one-clock `rd_valid`.
- R9: Chip enable goes low tCS+1 clocks (timing word 0 bits 18:16) before the first write-strobe fall. It stays low for tCH+1 clocks (bits 21:19) after the last phase of the sequence.
- R10: At the end of a sequence, `done` is high for exactly one clock, and `cmd_req` is high on the following clock.
- R11: When `run` falls, on the next clock chip enable is high, `cmd_req` is low and no `done` follows for the abandoned sequence.
- R12: CLE and ALE are never high together, and the write and read strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run level; low forces idle |
| desc_wr | input | 1 | Descriptor word write strobe |
| desc_data | input | 32 | Descriptor word |
| tim0 | input | 32 | Strobe timing counts (tCH, tCS, tWH, tWP, tRH, tRP) |
| tim1 | input | 32 | Wait counts (tR, tWHR, tAR) |
| cmd_req | output | 1 | Ready to accept descriptor words |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Bus value driven to the device |
| io_oe | output | 1 | Bus output enable |
| io_in | input | 8 | Bus value from the device |
| rb | input | 1 | Device ready (high) / busy (low) |
| rd_data | output | 8 | Byte read back from the device |
| rd_valid | output | 1 | One-clock strobe for `rd_data` |
| done | output | 1 | One-clock sequence completion pulse |

## Verification
The hardest state to reach from the ports is the abort. The sequencer must be caught in the middle of a sequence and then released with nothing left behind. The bench holds `rb` low during a program command so the block parks in its busy wait, and then drops `run` there. It checks that the pins are released at once, that no completion pulse ever follows, and that a fresh descriptor afterwards runs cleanly from the first word. The busy-wait floor is covered separately by an erase with `rb` already high, so the only delay comes from the tR count and can be timed exactly.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int RD_BYTES = 8,
  parameter int CNT_W    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        desc_wr,
  input  logic [31:0] desc_data,
  input  logic [31:0] tim0,
  input  logic [31:0] tim1,
  output logic        cmd_req,
  output logic        ce_n,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  io_out,
  output logic        io_oe,
  input  logic [7:0]  io_in,
  input  logic        rb,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done
);

  localparam int RC_W = $clog2(RD_BYTES + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RD_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_CS, S_WLO, S_WHI, S_GAP,
    S_RLO, S_RHI, S_TR, S_BUSY, S_HOLD, S_DONE
  } st_t;

  typedef enum logic [1:0] {K_CMD1, K_ADDR, K_CMD2} kind_t;

  st_t              st, nx_st;
  kind_t            kind, nx_kind;
  logic [2:0]       ai, nx_ai;
  logic [CNT_W-1:0] cnt, nx_cnt;
  logic [1:0]       wc;
  logic [31:0]      w0, w1, w2;
  logic [RC_W-1:0]  rc;

  // descriptor fields
  logic [7:0] op1, op2;
  logic [2:0] nadr, ctype;
  logic       dbc, is_rd, is_bsy;
  assign op1   = w0[7:0];
  assign op2   = w0[15:8];
  assign nadr  = w0[18:16];
  assign dbc   = w0[19];
  assign ctype = w0[23:21];
  assign is_rd  = (ctype == 3'd3) || (ctype == 3'd4);
  assign is_bsy = dbc && ((ctype == 3'd1) || (ctype == 3'd2));

  // timing fields, widened to the counter
  logic [CNT_W-1:0] t_ch, t_cs, t_wh, t_wp, t_rh, t_rp, t_r, t_whr, t_ar;
  assign t_ch  = CNT_W'(tim0[21:19]);
  assign t_cs  = CNT_W'(tim0[18:16]);
  assign t_wh  = CNT_W'(tim0[13:11]);
  assign t_wp  = CNT_W'(tim0[10:8]);
  assign t_rh  = CNT_W'(tim0[5:3]);
  assign t_rp  = CNT_W'(tim0[2:0]);
  assign t_r   = CNT_W'(tim1[31:16]);
  assign t_whr = CNT_W'(tim1[7:4]);
  assign t_ar  = CNT_W'(tim1[3:0]);

  logic [63:0] abuf;
  logic [7:0]  abyte;
  assign abuf  = {w2, w1};
  assign abyte = abuf[{ai, 3'b000} +: 8];

  // where to go once a write cycle has completed
  always_comb begin
    nx_st   = S_HOLD;
    nx_kind = kind;
    nx_ai   = ai;
    nx_cnt  = t_ch;
    if (kind == K_CMD1 && nadr != 3'd0) begin
      nx_st = S_WLO; nx_kind = K_ADDR; nx_ai = 3'd0; nx_cnt = t_wp;
    end else if (kind == K_ADDR && ({1'b0, ai} + 4'd1) < {1'b0, nadr}) begin
      nx_st = S_WLO; nx_ai = ai + 3'd1; nx_cnt = t_wp;
    end else if (kind != K_CMD2 && dbc) begin
      nx_st = S_WLO; nx_kind = K_CMD2; nx_cnt = t_wp;
    end else if (is_rd) begin
      nx_st = S_GAP; nx_cnt = (kind == K_ADDR) ? t_ar : t_whr;
    end else if (is_bsy) begin
      nx_st = S_TR; nx_cnt = t_r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_CMD1; ai <= '0; cnt <= '0; wc <= '0;
      w0 <= '0; w1 <= '0; w2 <= '0; rc <= '0;
      rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (!run) begin
        st <= S_IDLE;
        wc <= '0;
      end else begin
        case (st)
          S_IDLE: begin st <= S_REQ; wc <= '0; end
          S_REQ: if (desc_wr) begin
            case (wc)
              2'd0:    w0 <= desc_data;
              2'd1:    w1 <= desc_data;
              default: w2 <= desc_data;
            endcase
            if (wc == 2'd2) begin
              wc <= '0; st <= S_CS; cnt <= t_cs;
            end else wc <= wc + 2'd1;
          end
          S_CS: if (cnt == '0) begin
            st <= S_WLO; kind <= K_CMD1; ai <= '0; cnt <= t_wp;
          end else cnt <= cnt - 1'b1;
          S_WLO: if (cnt == '0) begin
            st <= S_WHI; cnt <= t_wh;
          end else cnt <= cnt - 1'b1;
          S_WHI: if (cnt == '0) begin
            st <= nx_st; kind <= nx_kind; ai <= nx_ai; cnt <= nx_cnt;
          end else cnt <= cnt - 1'b1;
          S_GAP: if (cnt == '0) begin
            st <= S_RLO; cnt <= t_rp; rc <= '0;
          end else cnt <= cnt - 1'b1;
          S_RLO: if (cnt == '0) begin
            rd_data <= io_in; rd_valid <= 1'b1;
            st <= S_RHI; cnt <= t_rh;
          end else cnt <= cnt - 1'b1;
          S_RHI: if (cnt == '0) begin
            if (rc == RC_LAST) begin
              st <= S_HOLD; cnt <= t_ch;
            end else begin
              rc <= rc + 1'b1; st <= S_RLO; cnt <= t_rp;
            end
          end else cnt <= cnt - 1'b1;
          S_TR: if (cnt == '0) st <= S_BUSY;
                else cnt <= cnt - 1'b1;
          S_BUSY: if (rb) begin st <= S_HOLD; cnt <= t_ch; end
          S_HOLD: if (cnt == '0) st <= S_DONE;
                  else cnt <= cnt - 1'b1;
          S_DONE: st <= S_REQ;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic wr_ph;
  assign wr_ph   = (st == S_WLO) || (st == S_WHI);
  assign cmd_req = (st == S_REQ);
  assign done    = (st == S_DONE);
  assign ce_n    = (st == S_IDLE) || (st == S_REQ) || (st == S_DONE);
  assign cle     = wr_ph && (kind != K_ADDR);
  assign ale     = wr_ph && (kind == K_ADDR);
  assign we_n    = (st != S_WLO);
  assign re_n    = (st != S_RLO);
  assign io_oe   = wr_ph;
  assign io_out  = (kind == K_ADDR) ? abyte : (kind == K_CMD2) ? op2 : op1;

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ce_n && !cmd_req && !done));
  p_done_then_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && run) |=> (cmd_req && !done));
  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !desc_wr && run) |=> cmd_req);
  p_rd_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(re_n));
  p_latch_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) && run |-> io_oe);
  p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && !rb) |=> !done);
  p_lines_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale) && (we_n || re_n));

endmodule

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, desc_wr = 1'b0, rb = 1'b1;
  logic [31:0] desc_data = '0;
  logic [31:0] tim0, tim1;
  logic cmd_req, ce_n, cle, ale, we_n, re_n, io_oe, rd_valid, done;
  logic [7:0] io_out, io_in, rd_data;

  // tCH=2 tCS=3 tWH=1 tWP=2 tRH=1 tRP=3 ; tR=20 tWHR=4 tAR=6
  assign tim0 = (32'd2 << 19) | (32'd3 << 16) | (32'd1 << 11) | (32'd2 << 8) | (32'd1 << 3) | 32'd3;
  assign tim1 = (32'd20 << 16) | (32'd4 << 4) | 32'd6;

  always #5 clk = ~clk;

  int re_rises;
  assign io_in = 8'h5A + 8'(re_rises * 3);

  nand_cmd_seq u_nand_cmd_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .desc_wr(desc_wr), .desc_data(desc_data),
    .tim0(tim0), .tim1(tim1), .cmd_req(cmd_req), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb(rb),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // pin monitor
  logic [9:0] byte_log [0:15];
  int lo_log [0:15];
  int hi_fall [0:15];
  logic [7:0] rd_log [0:15];
  logic [9:0] cur;
  int nb, lo_len, hi_since, cs_cnt, done_cnt, done_gap, re_gap, re_lo, rd_lo, nrd;
  logic prev_we = 1'b1, prev_re = 1'b1;

  task automatic clr_mon();
    nb = 0; lo_len = 0; hi_since = 0; cs_cnt = 0; done_gap = -1; re_gap = -1;
    re_lo = 0; rd_lo = -1; nrd = 0; re_rises = 0;
  endtask

  initial begin clr_mon(); done_cnt = 0; end

  always @(negedge clk) begin
    if (done) begin done_cnt++; done_gap = hi_since; end
    if (rd_valid && nrd < 16) begin rd_log[nrd] = rd_data; nrd++; end
    if (!re_n) begin
      if (prev_re && re_gap < 0) re_gap = hi_since;
      re_lo++;
    end else if (!prev_re) begin
      rd_lo = re_lo; re_lo = 0; re_rises++;
    end
    if (!ce_n && we_n && nb == 0 && lo_len == 0) cs_cnt++;
    if (!we_n) begin
      if (prev_we && nb < 16) hi_fall[nb] = hi_since;
      lo_len++; cur = {cle, ale, io_out};
    end else begin
      if (!prev_we) begin
        if (nb < 16) begin byte_log[nb] = cur; lo_log[nb] = lo_len; end
        nb++; lo_len = 0; hi_since = 0;
      end
      hi_since++;
    end
    prev_we = we_n; prev_re = re_n;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); #1; endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    int k = 0;
    while (!cmd_req && k < 100) begin step(); k++; end
    desc_wr = 1'b1; desc_data = a; step();
    desc_data = b; step();
    desc_data = c; step();
    desc_wr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int start = done_cnt;
    int k = 0;
    while (done_cnt == start && k < 3000) begin step(); k++; end
    check({req, " done seen"}, int'(done_cnt != start), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run = 1'b0;
    repeat (3) step();
    rst_n = 1'b1; step(); step();
    check("R1 ce_n", ce_n, 1); check("R1 we_n", we_n, 1); check("R1 re_n", re_n, 1);
    check("R1 cle/ale", {cle, ale}, 0); check("R1 io_oe", io_oe, 0);
    check("R1 cmd_req", cmd_req, 0); check("R1 done", done, 0);
  endtask

  task automatic t_ignore();
    clr_mon();
    desc_wr = 1'b1; desc_data = 32'h00A0_00FF; repeat (3) step(); desc_wr = 1'b0;
    repeat (5) step();
    check("R2 no start while stopped", int'(ce_n) + nb, 1);
    run = 1'b1; step();
    check("R2 cmd_req after run", cmd_req, 1);
    repeat (10) step();
    check("R2 cmd_req held", cmd_req, 1);
    check("R2 nothing issued", int'(ce_n) + nb, 1);
  endtask

  task automatic t_reset_cmd();
    clr_mon();
    send(32'h00A0_00FF, 32'h0, 32'h0);   // type 5, no address, single opcode
    wait_done("R10");
    check("R4 byte0", byte_log[0], {2'b10, 8'hFF});
    check("R4 we low width", lo_log[0], 3);
    check("R9 ce setup", cs_cnt, 4);
    check("R9 ce hold", done_gap, 5);
    check("R6 single byte", nb, 1);
    step();
    check("R10 done width", done, 0);
    check("R10 cmd_req after done", cmd_req, 1);
  endtask

  task automatic t_program();
    int k = 0;
    int d0;
    clr_mon(); rb = 1'b0;
    send(32'h0020_0000 | 32'h0008_0000 | 32'h0005_0000 | 32'h0000_1080, 32'h4433_2211, 32'h0000_0055);
    while (nb < 7 && k < 500) begin step(); k++; end
    d0 = done_cnt;
    repeat (60) step();
    check("R7 held while busy", done_cnt - d0, 0);
    rb = 1'b1;
    wait_done("R7");
    check("R3/R4 cmd1", byte_log[0], {2'b10, 8'h80});
    check("R5 addr0", byte_log[1], {2'b01, 8'h11});
    check("R5 addr1", byte_log[2], {2'b01, 8'h22});
    check("R5 addr3", byte_log[4], {2'b01, 8'h44});
    check("R5 addr4 from word2", byte_log[5], {2'b01, 8'h55});
    check("R6 cmd2", byte_log[6], {2'b10, 8'h10});
    check("R4 we high width", hi_fall[1], 2);
    check("R6 byte count", nb, 7);
  endtask

  task automatic t_erase();
    clr_mon(); rb = 1'b1;
    send(32'h0040_0000 | 32'h0008_0000 | 32'h0003_0000 | 32'h0000_D060, 32'h00AB_CDEF, 32'h0);
    wait_done("R7");
    check("R3 erase addr count", nb, 5);
    check("R5 erase row0", byte_log[1], {2'b01, 8'hEF});
    check("R5 erase row2", byte_log[3], {2'b01, 8'hAB});
    check("R6 erase cmd2", byte_log[4], {2'b10, 8'hD0});
    check("R7 min busy wait", done_gap, 27);
  endtask

  task automatic t_status();
    clr_mon();
    send(32'h0080_0070, 32'h0, 32'h0);
    wait_done("R8");
    check("R8 cmd only", nb, 1);
    check("R8 tWHR gap", re_gap, 7);
    check("R8 byte count", nrd, 8);
    check("R8 re low width", rd_lo, 4);
    for (int i = 0; i < 8; i++) check("R8 status byte", rd_log[i], 8'(8'h5A + i * 3));
  endtask

  task automatic t_readid();
    clr_mon();
    send(32'h0060_0000 | 32'h0001_0000 | 32'h0000_0090, 32'h0, 32'h0);
    wait_done("R8");
    check("R5 id addr", byte_log[1], {2'b01, 8'h00});
    check("R8 tAR gap", re_gap, 9);
    check("R8 id bytes", nrd, 8);
  endtask

  task automatic t_nodbc();
    clr_mon(); rb = 1'b0;
    send(32'h0020_0000 | 32'h0002_0000 | 32'h0000_1080, 32'h0000_BBAA, 32'h0);
    wait_done("R7");
    check("R6 no cmd2", nb, 3);
    check("R6 last is addr", byte_log[2], {2'b01, 8'hBB});
    check("R7 no busy wait", done_gap, 5);
    rb = 1'b1;
  endtask

  task automatic t_abort();
    int k = 0;
    int d0;
    clr_mon(); rb = 1'b0;
    send(32'h0020_0000 | 32'h0008_0000 | 32'h0005_0000 | 32'h0000_1080, 32'h4433_2211, 32'h0000_0055);
    while (nb < 7 && k < 500) begin step(); k++; end
    repeat (30) step();
    d0 = done_cnt;
    run = 1'b0; step();
    check("R11 ce released", ce_n, 1);
    check("R11 no cmd_req", cmd_req, 0);
    repeat (10) step();
    rb = 1'b1;
    repeat (10) step();
    check("R11 no done", done_cnt - d0, 0);
    run = 1'b1; clr_mon();
    send(32'h00A0_00FF, 32'h0, 32'h0);
    wait_done("R11");
    check("R11 clean restart", byte_log[0], {2'b10, 8'hFF});
    check("R11 restart bytes", nb, 1);
  endtask

  initial begin
    t_reset();
    t_ignore();
    t_reset_cmd();
    t_program();
    t_erase();
    t_status();
    t_readid();
    t_nodbc();
    t_abort();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule